// File: doc/BRIEF.md
# Register-Controlled Clock Source Selector

This block drives one output clock from one of `N_SRC` input clocks. Software chooses the source by writing a 32-bit control word. A select field sits inside that word at bit `SEL_LSB` and is `FIELD_W` bits wide. A build-time parameter sets how the field's value maps to a source number:

- plain binary,
- binary offset by one,
- one bit per source,
- a programmed lookup list that is searched in reverse to recover the source number.

Two further parameters change how the word is written. One makes the word writable a bit at a time through a mask carried in the upper half-word. The other locks the word so that writes change nothing.

A write whose field names no source is rejected. The current source stays in use and an error flag is raised. When an accepted write changes the source, each input clock's enable moves through a synchronizer in that clock's own domain. The outgoing clock is gated off on its falling edge before the incoming clock is gated on at its own falling edge, so the output never carries a shortened pulse. A status output reports which source is actually driving the output, and a busy flag shows that a change is still in flight.

Top module: `clksel_mux`

## Requirements
- R1: After reset the control word reads as the field code of source 0 placed at `SEL_LSB`, with every other bit 0, and the error flag is 0. Once the handshake completes, busy is 0, the active index is 0 and the output follows source 0.
- R2: In plain encoding (`CODE=SEL_PLAIN`), a field value v below `N_SRC` selects source v. Any larger value is invalid.
- R3: In offset encoding (`CODE=SEL_PLUS1`), a field value v from 1 to `N_SRC` selects source v-1. The value 0 and values above `N_SRC` are invalid.
- R4: In one-hot encoding (`CODE=SEL_ONEHOT`), the value 1<<i selects source i. Zero, a value with two or more bits set, or a bit at or above `N_SRC` is invalid.
- R5: In lookup encoding (`CODE=SEL_LOOKUP`), entry i of `LUT` is bits [i*FIELD_W +: FIELD_W]. A field equal to entry i selects source i, and the lowest i wins on duplicates. Any other value is invalid.
- R6: A write that decodes to an invalid field leaves the whole control word and the selected source unchanged, and sets the error flag. The next accepted write clears the flag.
- R7: With `HALF_MASK=1`, bit b of the low half-word takes `wr_data[b]` only when `wr_data[16+b]` is 1, and otherwise keeps its value. The upper half-word always reads 0. With `HALF_MASK=0`, an accepted write stores all 32 bits, and they read back unchanged.
- R8: With `LOCKED=1`, writes change neither the control word, nor the selected source, nor the error flag.
- R9: At most one source enable is on at any time. After a switch completes, `clk_out` equals the selected source clock. No output pulse is shorter than the shortest half-period among the sources.
- R10: When an accepted write changes the source, busy is 1 from the following cycle until the new enable has been seen in the control domain. While busy is 0, the active index equals the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctrl_clk | input | 1 | Control clock for register writes and status |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| src_clk | input | N_SRC | Candidate source clocks |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data (upper half is the bit mask when `HALF_MASK=1`) |
| rd_data | output | 32 | Current control word |
| sel_err | output | 1 | Last non-ignored write carried an invalid select field |
| active_idx | output | $clog2(N_SRC) | Source whose enable is seen on in the control domain |
| switch_busy | output | 1 | Enables do not yet match the selected source |
| clk_out | output | 1 | Gated output clock |

## Verification
A decoder fault shows up on the cycle after the write, either as a wrong `rd_data` value or a wrong error flag. It also shows up some tens of cycles later as an `active_idx` that names the wrong source. A stuck or overlapping enable makes `clk_out` differ from the selected source once the switch has settled, or produces a pulse shorter than any source half-period during the changeover. The bench checks both after every write. A pacing fault in the status path leaves busy high past the settling window, or drops it while the active index is still stale.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  typedef enum logic [1:0] {
    SEL_PLAIN  = 2'd0,
    SEL_PLUS1  = 2'd1,
    SEL_ONEHOT = 2'd2,
    SEL_LOOKUP = 2'd3
  } sel_code_e;

  localparam int CTRL_W = 32;
  localparam int HALF_W = CTRL_W / 2;

  // Bitwise-masked update: upper half of wdata chooses which low bits change.
  function automatic logic [CTRL_W-1:0] apply_half_mask(input logic [CTRL_W-1:0] cur,
                                                        input logic [CTRL_W-1:0] wdata);
    logic [HALF_W-1:0] keep;
    logic [HALF_W-1:0] lo;
    keep = wdata[CTRL_W-1:HALF_W];
    lo   = (cur[HALF_W-1:0] & ~keep) | (wdata[HALF_W-1:0] & keep);
    return {{HALF_W{1'b0}}, lo};
  endfunction

endpackage

// File: rtl/clksel_codec.sv
module clksel_codec
  import clksel_pkg::*;
#(
  parameter int                         N_SRC   = 4,
  parameter int                         FIELD_W = 4,
  parameter sel_code_e                  CODE    = SEL_PLAIN,
  parameter logic [N_SRC*FIELD_W-1:0]   LUT     = '0,
  localparam int                        IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [FIELD_W-1:0] field,
  output logic               hit,
  output logic [IDX_W-1:0]   idx,
  output logic [FIELD_W-1:0] home_code
);

  // Field code that names source i under the chosen encoding.
  function automatic logic [FIELD_W-1:0] code_of(input int i);
    case (CODE)
      SEL_PLAIN:  return FIELD_W'(i);
      SEL_PLUS1:  return FIELD_W'(i + 1);
      SEL_ONEHOT: return FIELD_W'(1) << i;
      default:    return LUT[i*FIELD_W +: FIELD_W];
    endcase
  endfunction

  // Reverse search; descending loop leaves the lowest matching index.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (field == code_of(i)) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assign home_code = code_of(0);

endmodule

// File: rtl/clksel_ctrl_reg.sv
module clksel_ctrl_reg
  import clksel_pkg::*;
#(
  parameter int                       N_SRC     = 4,
  parameter int                       SEL_LSB   = 4,
  parameter int                       FIELD_W   = 4,
  parameter sel_code_e                CODE      = SEL_PLAIN,
  parameter logic [N_SRC*FIELD_W-1:0] LUT       = '0,
  parameter bit                       HALF_MASK = 1'b0,
  parameter bit                       LOCKED    = 1'b0,
  localparam int                      IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [IDX_W-1:0]  sel_idx,
  output logic              sel_err
);

  logic [CTRL_W-1:0]  next_word;
  logic [FIELD_W-1:0] next_field;
  logic               dec_hit;
  logic [IDX_W-1:0]   dec_idx;
  logic [FIELD_W-1:0] home_code;
  logic [CTRL_W-1:0]  reset_word;
  logic               wr_take;
  logic               wr_reject;

  generate
    if (HALF_MASK) begin : g_masked
      assign next_word = apply_half_mask(ctrl_q, wr_data);
    end else begin : g_full
      assign next_word = wr_data;
    end
  endgenerate

  assign next_field = next_word[SEL_LSB +: FIELD_W];

  clksel_codec #(
    .N_SRC(N_SRC), .FIELD_W(FIELD_W), .CODE(CODE), .LUT(LUT)
  ) u_codec (
    .field(next_field), .hit(dec_hit), .idx(dec_idx), .home_code(home_code)
  );

  assign reset_word = CTRL_W'(home_code) << SEL_LSB;
  assign wr_take    = wr_en && !LOCKED && dec_hit;
  assign wr_reject  = wr_en && !LOCKED && !dec_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= reset_word;
      sel_idx <= '0;
      sel_err <= 1'b0;
    end else if (wr_take) begin
      ctrl_q  <= next_word;
      sel_idx <= dec_idx;
      sel_err <= 1'b0;
    end else if (wr_reject) begin
      sel_err <= 1'b1;
    end
  end

  // Accepted write: selection follows the decoder (R2, R3, R4, R5)
  assert_take_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> (sel_idx == $past(dec_idx)) && !sel_err);

  assert_reject_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> $stable(sel_idx) && $stable(ctrl_q) && sel_err);

  generate
    if (LOCKED) begin : g_lock_chk
      assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(ctrl_q) && $stable(sel_idx) && $stable(sel_err));
    end
    if (HALF_MASK) begin : g_mask_chk
      assert_unmasked_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((ctrl_q[HALF_W-1:0] ^ $past(ctrl_q[HALF_W-1:0]))
                   & ~$past(wr_data[CTRL_W-1:HALF_W])) == '0);
      assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CTRL_W-1:HALF_W] == '0);
    end
  endgenerate

endmodule

// File: rtl/clksel_src_gate.sv
module clksel_src_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic want,
  input  logic rivals_on,
  output logic gate_on
);

  logic [SYNC_STAGES-1:0] pipe;

  // Request is seen only once every other source is gated off.
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[SYNC_STAGES-2:0], want & ~rivals_on};
  end

  // Enable changes while the source is low, so no partial pulse leaks out.
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) gate_on <= 1'b0;
    else        gate_on <= pipe[SYNC_STAGES-1];
  end

endmodule

// File: rtl/clksel_mux.sv
module clksel_mux
  import clksel_pkg::*;
#(
  parameter int                       N_SRC       = 4,
  parameter int                       SEL_LSB     = 4,
  parameter int                       FIELD_W     = 4,
  parameter sel_code_e                CODE        = SEL_PLAIN,
  parameter logic [N_SRC*FIELD_W-1:0] LUT         = 16'h93C5,
  parameter bit                       HALF_MASK   = 1'b0,
  parameter bit                       LOCKED      = 1'b0,
  parameter int                       SYNC_STAGES = 2,
  localparam int                      IDX_W       = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              ctrl_clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_clk,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              sel_err,
  output logic [IDX_W-1:0]  active_idx,
  output logic              switch_busy,
  output logic              clk_out
);

  function automatic logic [N_SRC-1:0] idx_to_hot(input logic [IDX_W-1:0] i);
    return N_SRC'(1) << i;
  endfunction

  function automatic logic [IDX_W-1:0] hot_to_idx(input logic [N_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_SRC - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic [IDX_W-1:0] sel_idx;
  logic [N_SRC-1:0] want_q;
  logic [N_SRC-1:0] src_on;
  logic [N_SRC-1:0] rivals;
  logic [N_SRC-1:0] seen_pipe [SYNC_STAGES];
  logic [N_SRC-1:0] on_seen;
  logic             settled;

  clksel_ctrl_reg #(
    .N_SRC(N_SRC), .SEL_LSB(SEL_LSB), .FIELD_W(FIELD_W), .CODE(CODE),
    .LUT(LUT), .HALF_MASK(HALF_MASK), .LOCKED(LOCKED)
  ) u_reg (
    .clk(ctrl_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(rd_data), .sel_idx(sel_idx), .sel_err(sel_err)
  );

  assign on_seen = seen_pipe[SYNC_STAGES-1];
  assign settled = (on_seen == want_q);

  // Target moves only after the previous handshake is fully observed.
  always_ff @(posedge ctrl_clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q <= idx_to_hot(IDX_W'(0));
      for (int s = 0; s < SYNC_STAGES; s++) seen_pipe[s] <= '0;
    end else begin
      seen_pipe[0] <= src_on;
      for (int s = 1; s < SYNC_STAGES; s++) seen_pipe[s] <= seen_pipe[s-1];
      if (settled) want_q <= idx_to_hot(sel_idx);
    end
  end

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
      assign rivals[g] = |(src_on & ~(N_SRC'(1) << g));
      clksel_src_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .src_clk(src_clk[g]), .rst_n(rst_n), .want(want_q[g]),
        .rivals_on(rivals[g]), .gate_on(src_on[g])
      );
    end
  endgenerate

  assign clk_out     = |(src_clk & src_on);
  assign active_idx  = hot_to_idx(on_seen);
  assign switch_busy = (on_seen != idx_to_hot(sel_idx));

  assert_single_source_R9: assert property (@(posedge ctrl_clk) disable iff (!rst_n)
    $onehot0(src_on));

  assert_one_target_R9: assert property (@(posedge ctrl_clk) disable iff (!rst_n)
    $onehot(want_q));

  assert_idle_matches_R10: assert property (@(posedge ctrl_clk) disable iff (!rst_n)
    !switch_busy |-> (active_idx == sel_idx));

endmodule

// File: tb/clksel_mux_bench.sv
module clksel_mux_bench;
  import clksel_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NK         = 5;
  localparam int MIN_HALF   = 4;
  localparam int MODE [NK]  = '{0, 1, 2, 3, 0};
  localparam bit HM   [NK]  = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam bit RO   [NK]  = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  logic ctrl_clk = 1'b0;
  logic rst_n    = 1'b0;
  logic s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
  logic [3:0] src_clk;

  always #(CLK_PERIOD/2) ctrl_clk = ~ctrl_clk;
  always #4  s0 = ~s0;
  always #6  s1 = ~s1;
  always #10 s2 = ~s2;
  always #8  s3 = ~s3;
  assign src_clk = {s3, s2, s1, s0};

  logic        we  [NK];
  logic [31:0] wd  [NK];
  logic [31:0] rd  [NK];
  logic [1:0]  act [NK];
  logic        bsy [NK];
  logic        err [NK];
  logic        cko [NK];

  clksel_mux u_clksel_mux (
    .ctrl_clk(ctrl_clk), .rst_n(rst_n), .src_clk(src_clk), .wr_en(we[0]), .wr_data(wd[0]),
    .rd_data(rd[0]), .sel_err(err[0]), .active_idx(act[0]), .switch_busy(bsy[0]), .clk_out(cko[0]));

  clksel_mux #(.CODE(SEL_PLUS1), .HALF_MASK(1'b1)) u_plus1 (
    .ctrl_clk(ctrl_clk), .rst_n(rst_n), .src_clk(src_clk), .wr_en(we[1]), .wr_data(wd[1]),
    .rd_data(rd[1]), .sel_err(err[1]), .active_idx(act[1]), .switch_busy(bsy[1]), .clk_out(cko[1]));

  clksel_mux #(.CODE(SEL_ONEHOT)) u_hot (
    .ctrl_clk(ctrl_clk), .rst_n(rst_n), .src_clk(src_clk), .wr_en(we[2]), .wr_data(wd[2]),
    .rd_data(rd[2]), .sel_err(err[2]), .active_idx(act[2]), .switch_busy(bsy[2]), .clk_out(cko[2]));

  clksel_mux #(.CODE(SEL_LOOKUP), .LUT(16'h93C5)) u_lut (
    .ctrl_clk(ctrl_clk), .rst_n(rst_n), .src_clk(src_clk), .wr_en(we[3]), .wr_data(wd[3]),
    .rd_data(rd[3]), .sel_err(err[3]), .active_idx(act[3]), .switch_busy(bsy[3]), .clk_out(cko[3]));

  clksel_mux #(.LOCKED(1'b1)) u_lock (
    .ctrl_clk(ctrl_clk), .rst_n(rst_n), .src_clk(src_clk), .wr_en(we[4]), .wr_data(wd[4]),
    .rd_data(rd[4]), .sel_err(err[4]), .active_idx(act[4]), .switch_busy(bsy[4]), .clk_out(cko[4]));

  int          tests = 0;
  int          fails = 0;
  bit          done  = 1'b0;
  logic [31:0] m_reg [NK];
  int          m_sel [NK];
  bit          m_err [NK];
  longint      last_t [NK];

  task automatic check(input bit ok, input string req, input string what,
                       input longint actv, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actv, expv);
    end
  endtask

  // Expected decode, written arithmetically per encoding (R2, R3, R4, R5).
  task automatic bdec(input int mode, input int f, output bit v, output int idx);
    v = 1'b0; idx = 0;
    case (mode)
      0: begin v = (f < 4); idx = f; end
      1: begin v = (f >= 1 && f <= 4); idx = f - 1; end
      2: begin v = (f != 0) && ((f & (f - 1)) == 0) && (f < 16); idx = $clog2(f); end
      default: begin
        v = 1'b1;
        case (f)
          5:  idx = 0;
          12: idx = 1;
          3:  idx = 2;
          9:  idx = 3;
          default: v = 1'b0;
        endcase
      end
    endcase
  endtask

  function automatic string rtag(input int k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R8";
    endcase
  endfunction

  // Pulse-width monitor: no output pulse narrower than any source half-period (R9).
  generate
    for (genvar g = 0; g < NK; g++) begin : g_mon
      always @(cko[g]) begin
        if (rst_n && ($time - last_t[g] < MIN_HALF)) begin
          tests++;
          fails++;
          $display("FAIL R9 short pulse inst %0d: actual %0d expected >= %0d",
                   g, $time - last_t[g], MIN_HALF);
        end
        last_t[g] = $time;
      end
    end
  endgenerate

  task automatic check_settled(input int k, input string req);
    repeat (40) @(negedge ctrl_clk);
    check(bsy[k] == 1'b0, (req == "R1") ? "R1" : "R10", "busy after settle", bsy[k], 0);
    check(int'(act[k]) == m_sel[k], (req == "R1") ? "R1" : "R10", "active index", act[k], m_sel[k]);
    #1;
    for (int t = 0; t < 8; t++) begin
      check(cko[k] == src_clk[m_sel[k]], "R9", "clk_out follows source", cko[k], src_clk[m_sel[k]]);
      #2;
    end
  endtask

  task automatic do_write(input int k, input logic [31:0] d);
    logic [31:0] cand;
    bit          v;
    int          idx;
    int          prev;
    cand = HM[k] ? {16'h0, (m_reg[k][15:0] & ~d[31:16]) | (d[15:0] & d[31:16])} : d;
    bdec(MODE[k], int'(cand[7:4]), v, idx);
    prev = m_sel[k];
    if (!RO[k]) begin
      if (v) begin
        m_reg[k] = cand;
        m_sel[k] = idx;
        m_err[k] = 1'b0;
      end else begin
        m_err[k] = 1'b1;
      end
    end
    @(negedge ctrl_clk);
    we[k] = 1'b1;
    wd[k] = d;
    @(negedge ctrl_clk);
    we[k] = 1'b0;
    check(rd[k] == m_reg[k], HM[k] ? "R7" : rtag(k), "control word", rd[k], m_reg[k]);
    check(err[k] == m_err[k], (v || RO[k]) ? rtag(k) : "R6", "error flag", err[k], m_err[k]);
    check(bsy[k] == (m_sel[k] != prev), "R10", "busy after write", bsy[k], (m_sel[k] != prev));
    check_settled(k, rtag(k));
  endtask

  initial begin
    repeat (150000) @(posedge ctrl_clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_reg = '{32'h0, 32'h10, 32'h10, 32'h50, 32'h0};
    for (int k = 0; k < NK; k++) begin
      we[k] = 1'b0; wd[k] = '0; m_sel[k] = 0; m_err[k] = 1'b0; last_t[k] = 0;
    end
    repeat (3) @(negedge ctrl_clk);
    rst_n = 1'b1;

    // R1: reset state of every variant
    for (int k = 0; k < NK; k++) begin
      check(rd[k] == m_reg[k], "R1", "reset control word", rd[k], m_reg[k]);
      check(err[k] == 1'b0, "R1", "reset error flag", err[k], 0);
      check_settled(k, "R1");
    end

    // R2: plain field, other bits stored as written
    for (int f = 0; f < 16; f++) do_write(0, 32'hA5C3_0009 | (f << 4));
    // R3 with R7: offset field through the half-word mask
    for (int f = 0; f < 16; f++) begin
      logic [15:0] m;
      m = (f % 3 == 0) ? 16'hFFFF : (f % 3 == 1) ? 16'h00F0 : 16'h000F;
      do_write(1, {m, 8'h12, 4'(f), 4'hA});
    end
    // R4: one-hot field, including zero and multi-bit values
    for (int f = 0; f < 16; f++) do_write(2, f << 4);
    // R5: lookup field with reverse search
    for (int f = 0; f < 16; f++) do_write(3, 32'h100 | (f << 4));
    // R8: locked register ignores every write
    for (int f = 0; f < 16; f++) do_write(4, 32'hFFFF_0000 | (f << 4));
    // R6: error flag cleared by a later accepted write
    do_write(0, 32'h70);
    do_write(0, 32'h20);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule